// File: doc/BRIEF.md
# Coprocessor Data-Transfer Primitive Sequencer

This block sits on the main-processor side of a coprocessor link. It services the request in which the coprocessor asks the processor to evaluate an effective address and move an operand between that location and the coprocessor's operand register. The block takes the decoded request: a direction bit, a 3-bit code naming which addressing classes are acceptable, and a byte count. It also takes the addressing mode and register number of the instruction. It latches all of these in the cycle it accepts the request, because the coprocessor replaces the request with a null one once it has been read.

From the latched copy, the block decides whether the request is legal. A legal request is moved in beats of up to four bytes through one of three handshake ports: memory, processor register, or coprocessor operand. Predecrement and postincrement modes also issue an address-register update before or after the data. An illegal request sends an abort strobe to the coprocessor control register and then a trap pulse, with no data movement.

The controller is one state machine. IDLE accepts a request (IDLE to CHECK). CHECK goes to ABORT when the request is illegal, to PRE for predecrement, and to FETCH otherwise. ABORT is followed by TRAP, then IDLE. PRE is followed by FETCH. FETCH goes to STORE on the source acknowledge. STORE goes back to FETCH while bytes remain. On the last beat STORE goes to POST for postincrement, or to DONE otherwise. POST is followed by DONE, then IDLE.

Top module: `cpxfer_seq`

## Requirements
- R1: `prim_take` is high only in the idle state while `prim_valid` is high. All request fields are captured in that cycle and later changes on those inputs have no effect on the transfer. Out of reset, every request, strobe and pulse output is low.
- R2: Mode codes are 0 data register, 1 address register, 2 indirect, 3 postincrement, 4 predecrement, 5 displacement, 6 absolute, 7 immediate. Class codes and the modes they accept are:
  - 0 control: modes 2, 5, 6
  - 1 alterable: modes 0 to 6
  - 2 memory-alterable: modes 2 to 6
  - 3 data-alterable: modes 0 and 2 to 6
  - 4 data: modes 0 and 2 to 7
  - 5 memory: modes 2 to 7
  - 6 any: all modes
  - 7: no mode
  A mode outside its class is illegal.
- R3: Register-direct modes (0, 1) accept only lengths 1, 2 and 4. The transfer is one beat on the register port with `reg_sel` = {mode bit 0, register number}.
- R4: Immediate mode (7) accepts length 1 or an even length, and only direction 0.
- R5: Memory modes accept any nonzero length. Length 0 is illegal in every mode. Beats carry 4 bytes at byte offsets 0, 4, 8, and so on, and the last beat carries the remaining 1 to 4 bytes. The beat sizes add up to the length.
- R6: Predecrement issues one `areg_upd` with `areg_dec`=1 on the selected register before the first data request.
- R7: Postincrement issues one `areg_upd` with `areg_dec`=0 in the cycle after the last beat completes. Other modes issue no update.
- R8: The update amount is the length, except that register 7 with length 1 steps by 2.
- R9: An illegal request raises `ctl_abort` for one cycle, then `trap` in the next cycle. It makes no data request and no register update.
- R10: Direction 0 reads the effective-address location (register port for modes 0 and 1, memory port otherwise) and writes each beat to the operand port. Direction 1 reads the operand port and writes the location. The written data equals the data read for that beat, and only one port requests at a time.
- R11: `done` pulses for one cycle after the last beat of a legal transfer. It comes one cycle after the last store acknowledge, or two cycles after it when a postincrement update intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| prim_valid | input | 1 | Transfer request present |
| prim_dir | input | 1 | 0: location to coprocessor, 1: coprocessor to location |
| prim_class | input | 3 | Acceptable addressing class code |
| prim_len | input | LW | Operand length in bytes |
| ea_mode | input | 3 | Addressing mode of the instruction |
| ea_reg | input | 3 | Register number of the instruction |
| prim_take | output | 1 | Request accepted and latched this cycle |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Memory beat is a write |
| mem_rdata | input | DW | Memory read data |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory beat complete |
| reg_req | output | 1 | Processor register access request |
| reg_we | output | 1 | Register access is a write |
| reg_sel | output | 4 | {address-register flag, register number} |
| reg_rdata | input | DW | Register read data |
| reg_wdata | output | DW | Register write data |
| reg_ack | input | 1 | Register access complete |
| opd_rd_req | output | 1 | Read beat from coprocessor operand register |
| opd_rdata | input | DW | Operand read data |
| opd_rd_ack | input | 1 | Operand read complete |
| opd_wr_req | output | 1 | Write beat to coprocessor operand register |
| opd_wdata | output | DW | Operand write data |
| opd_wr_ack | input | 1 | Operand write complete |
| beat_size | output | SW | Bytes in the current beat |
| beat_off | output | LW | Byte offset of the current beat |
| areg_upd | output | 1 | Address-register update strobe |
| areg_dec | output | 1 | 1: subtract, 0: add |
| areg_sel | output | 3 | Address register to update |
| areg_amt | output | LW | Update amount in bytes |
| ctl_abort | output | 1 | Abort write to coprocessor control register |
| trap | output | 1 | Emulation trap pulse |
| done | output | 1 | Transfer complete pulse |

## Verification
Two things can happen in the same cycle: the request inputs change, and the sequencer makes its legality decision. The decision must come from the latched copy, as the request turns null right after being read. To provoke this, the bench overwrites every request field with random values one cycle after `prim_take` and keeps `prim_valid` high through the transfer and during the `done` or `trap` cycle. The bench then compares the ports used, the beat sizes, the abort or update behaviour and the take count against values computed from the original request. A second take, or any behaviour that follows the overwritten fields, is reported.

// File: rtl/cpxfer_pkg.sv
package cpxfer_pkg;

    typedef enum logic [2:0] {
        EA_DREG    = 3'd0,
        EA_AREG    = 3'd1,
        EA_IND     = 3'd2,
        EA_POSTINC = 3'd3,
        EA_PREDEC  = 3'd4,
        EA_DISP    = 3'd5,
        EA_ABS     = 3'd6,
        EA_IMM     = 3'd7
    } ea_mode_e;

    typedef enum logic [2:0] {
        CL_CTRL   = 3'd0,
        CL_ALT    = 3'd1,
        CL_MEMALT = 3'd2,
        CL_DATALT = 3'd3,
        CL_DATA   = 3'd4,
        CL_MEM    = 3'd5,
        CL_ANY    = 3'd6,
        CL_NONE   = 3'd7
    } ea_class_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CHECK,
        S_ABORT,
        S_TRAP,
        S_PRE,
        S_FETCH,
        S_STORE,
        S_POST,
        S_DONE
    } seq_state_e;

    // bit i set: addressing mode i belongs to the class
    function automatic logic [7:0] class_mask(input ea_class_e c);
        logic [7:0] m;
        unique case (c)
            CL_CTRL:   m = 8'b0110_0100;
            CL_ALT:    m = 8'b0111_1111;
            CL_MEMALT: m = 8'b0111_1100;
            CL_DATALT: m = 8'b0111_1101;
            CL_DATA:   m = 8'b1111_1101;
            CL_MEM:    m = 8'b1111_1100;
            CL_ANY:    m = 8'b1111_1111;
            default:   m = 8'b0000_0000;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cpxfer_legal.sv
module cpxfer_legal
    import cpxfer_pkg::*;
#(
    parameter int LW = 8
) (
    input  logic [2:0]    cls,
    input  logic [2:0]    mode,
    input  logic [LW-1:0] len,
    input  logic          dir,
    output logic          ok
);
    logic [7:0] mask;
    logic       class_ok;
    logic       len_ok;
    ea_mode_e   m;

    always_comb begin
        m        = ea_mode_e'(mode);
        mask     = class_mask(ea_class_e'(cls));
        class_ok = mask[mode];
        if (len == '0) begin
            len_ok = 1'b0;
        end else if (m == EA_DREG || m == EA_AREG) begin
            len_ok = (len == LW'(1)) || (len == LW'(2)) || (len == LW'(4));
        end else if (m == EA_IMM) begin
            len_ok = ((len == LW'(1)) || !len[0]) && !dir;
        end else begin
            len_ok = 1'b1;
        end
        ok = class_ok && len_ok;
    end

endmodule

// File: rtl/cpxfer_step.sv
module cpxfer_step
    import cpxfer_pkg::*;
#(
    parameter int LW = 8
) (
    input  logic [2:0]    mode,
    input  logic [2:0]    regno,
    input  logic [LW-1:0] len,
    output logic          pre,
    output logic          post,
    output logic [LW-1:0] amt
);
    localparam logic [2:0] SP_NUM = 3'd7;

    always_comb begin
        pre  = (ea_mode_e'(mode) == EA_PREDEC);
        post = (ea_mode_e'(mode) == EA_POSTINC);
        amt  = ((regno == SP_NUM) && (len == LW'(1))) ? LW'(2) : len;
    end

endmodule

// File: rtl/cpxfer_beat.sv
module cpxfer_beat #(
    parameter int LW = 8,
    parameter int BB = 4,
    localparam int SW = $clog2(BB) + 1
) (
    input  logic [LW-1:0] rem,
    output logic [SW-1:0] size,
    output logic          last
);
    always_comb begin
        if (rem >= LW'(BB)) begin
            size = SW'(BB);
        end else begin
            size = rem[SW-1:0];
        end
        last = (rem <= LW'(BB));
    end

endmodule

// File: rtl/cpxfer_seq.sv
module cpxfer_seq
    import cpxfer_pkg::*;
#(
    parameter int LW = 8,
    parameter int DW = 32,
    localparam int BB = DW / 8,
    localparam int SW = $clog2(BB) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prim_valid,
    input  logic          prim_dir,
    input  logic [2:0]    prim_class,
    input  logic [LW-1:0] prim_len,
    input  logic [2:0]    ea_mode,
    input  logic [2:0]    ea_reg,
    output logic          prim_take,
    output logic          mem_req,
    output logic          mem_we,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    output logic          reg_req,
    output logic          reg_we,
    output logic [3:0]    reg_sel,
    input  logic [DW-1:0] reg_rdata,
    output logic [DW-1:0] reg_wdata,
    input  logic          reg_ack,
    output logic          opd_rd_req,
    input  logic [DW-1:0] opd_rdata,
    input  logic          opd_rd_ack,
    output logic          opd_wr_req,
    output logic [DW-1:0] opd_wdata,
    input  logic          opd_wr_ack,
    output logic [SW-1:0] beat_size,
    output logic [LW-1:0] beat_off,
    output logic          areg_upd,
    output logic          areg_dec,
    output logic [2:0]    areg_sel,
    output logic [LW-1:0] areg_amt,
    output logic          ctl_abort,
    output logic          trap,
    output logic          done
);
    seq_state_e    state_q, state_d;

    logic          dir_q;
    logic [2:0]    cls_q;
    logic [LW-1:0] len_q;
    logic [2:0]    mode_q;
    logic [2:0]    reg_q;
    logic [LW-1:0] off_q;
    logic [DW-1:0] buf_q;

    logic          legal;
    logic          pre_mode;
    logic          post_mode;
    logic [LW-1:0] step_amt;
    logic [SW-1:0] bsize;
    logic          blast;
    logic          regdir;
    logic          src_ack;
    logic          dst_ack;
    logic [DW-1:0] src_data;

    cpxfer_legal #(.LW(LW)) u_legal (
        .cls  (cls_q),
        .mode (mode_q),
        .len  (len_q),
        .dir  (dir_q),
        .ok   (legal)
    );

    cpxfer_step #(.LW(LW)) u_step (
        .mode  (mode_q),
        .regno (reg_q),
        .len   (len_q),
        .pre   (pre_mode),
        .post  (post_mode),
        .amt   (step_amt)
    );

    cpxfer_beat #(.LW(LW), .BB(BB)) u_beat (
        .rem  (len_q - off_q),
        .size (bsize),
        .last (blast)
    );

    assign regdir   = (ea_mode_e'(mode_q) == EA_DREG) || (ea_mode_e'(mode_q) == EA_AREG);
    assign src_ack  = dir_q ? opd_rd_ack : (regdir ? reg_ack : mem_ack);
    assign dst_ack  = dir_q ? (regdir ? reg_ack : mem_ack) : opd_wr_ack;
    assign src_data = dir_q ? opd_rdata : (regdir ? reg_rdata : mem_rdata);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // latched request and beat datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= 1'b0;
            cls_q  <= '0;
            len_q  <= '0;
            mode_q <= '0;
            reg_q  <= '0;
            off_q  <= '0;
            buf_q  <= '0;
        end else begin
            if (prim_take) begin
                dir_q  <= prim_dir;
                cls_q  <= prim_class;
                len_q  <= prim_len;
                mode_q <= ea_mode;
                reg_q  <= ea_reg;
                off_q  <= '0;
            end
            if (state_q == S_FETCH && src_ack) begin
                buf_q <= src_data;
            end
            if (state_q == S_STORE && dst_ack) begin
                off_q <= off_q + LW'(bsize);
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (prim_valid) state_d = S_CHECK;
            S_CHECK: begin
                if (!legal)        state_d = S_ABORT;
                else if (pre_mode) state_d = S_PRE;
                else               state_d = S_FETCH;
            end
            S_ABORT: state_d = S_TRAP;
            S_TRAP:  state_d = S_IDLE;
            S_PRE:   state_d = S_FETCH;
            S_FETCH: if (src_ack) state_d = S_STORE;
            S_STORE: begin
                if (dst_ack) begin
                    if (!blast)         state_d = S_FETCH;
                    else if (post_mode) state_d = S_POST;
                    else                state_d = S_DONE;
                end
            end
            S_POST:  state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        prim_take  = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        reg_req    = 1'b0;
        reg_we     = 1'b0;
        opd_rd_req = 1'b0;
        opd_wr_req = 1'b0;
        areg_upd   = 1'b0;
        areg_dec   = 1'b0;
        ctl_abort  = 1'b0;
        trap       = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            S_IDLE:  prim_take = prim_valid;
            S_ABORT: ctl_abort = 1'b1;
            S_TRAP:  trap = 1'b1;
            S_PRE: begin
                areg_upd = 1'b1;
                areg_dec = 1'b1;
            end
            S_FETCH: begin
                if (dir_q)       opd_rd_req = 1'b1;
                else if (regdir) reg_req = 1'b1;
                else             mem_req = 1'b1;
            end
            S_STORE: begin
                if (!dir_q) begin
                    opd_wr_req = 1'b1;
                end else if (regdir) begin
                    reg_req = 1'b1;
                    reg_we  = 1'b1;
                end else begin
                    mem_req = 1'b1;
                    mem_we  = 1'b1;
                end
            end
            S_POST:  areg_upd = 1'b1;
            S_DONE:  done = 1'b1;
            default: ;
        endcase
    end

    assign reg_sel   = {mode_q[0], reg_q};
    assign mem_wdata = buf_q;
    assign reg_wdata = buf_q;
    assign opd_wdata = buf_q;
    assign beat_size = bsize;
    assign beat_off  = off_q;
    assign areg_sel  = reg_q;
    assign areg_amt  = step_amt;

endmodule

// File: rtl/cpxfer_seq_chk.sv
module cpxfer_seq_chk #(
    parameter int LW = 8,
    parameter int BB = 4,
    parameter int SW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          prim_take,
    input logic          mem_req,
    input logic          reg_req,
    input logic          opd_rd_req,
    input logic          opd_wr_req,
    input logic [SW-1:0] beat_size,
    input logic          areg_upd,
    input logic          areg_dec,
    input logic [2:0]    areg_sel,
    input logic [LW-1:0] areg_amt,
    input logic          ctl_abort,
    input logic          trap,
    input logic          done
);
    logic any_req;
    assign any_req = mem_req || reg_req || opd_rd_req || opd_wr_req;

    // R1
    take_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prim_take |=> !prim_take);

    // R1
    take_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !prim_take);

    // R5
    beat_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |-> (beat_size != '0) && (beat_size <= SW'(BB)));

    // R6
    pre_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (areg_upd && areg_dec) |=> (mem_req || opd_rd_req));

    // R7
    post_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (areg_upd && !areg_dec) |=> done);

    // R8
    sp_word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (areg_upd && areg_sel == 3'd7) |-> (areg_amt != LW'(1)));

    // R9
    abort_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_abort |=> (trap && !ctl_abort));

    // R9
    abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_abort |-> !(any_req || areg_upd));

    // R10
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, reg_req, opd_rd_req, opd_wr_req}));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind cpxfer_seq cpxfer_seq_chk #(.LW(LW), .BB(BB), .SW(SW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .prim_take  (prim_take),
    .mem_req    (mem_req),
    .reg_req    (reg_req),
    .opd_rd_req (opd_rd_req),
    .opd_wr_req (opd_wr_req),
    .beat_size  (beat_size),
    .areg_upd   (areg_upd),
    .areg_dec   (areg_dec),
    .areg_sel   (areg_sel),
    .areg_amt   (areg_amt),
    .ctl_abort  (ctl_abort),
    .trap       (trap),
    .done       (done)
);

// File: tb/cpxfer_seq_test.sv
`timescale 1ns/1ps
module cpxfer_seq_test;
    localparam int LW = 8;
    localparam int DW = 32;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prim_valid = 1'b0;
    logic          prim_dir = 1'b0;
    logic [2:0]    prim_class = '0;
    logic [LW-1:0] prim_len = '0;
    logic [2:0]    ea_mode = '0;
    logic [2:0]    ea_reg = '0;
    logic          prim_take;
    logic          mem_req, mem_we, mem_ack;
    logic [DW-1:0] mem_rdata, mem_wdata;
    logic          reg_req, reg_we, reg_ack;
    logic [3:0]    reg_sel;
    logic [DW-1:0] reg_rdata, reg_wdata;
    logic          opd_rd_req, opd_rd_ack, opd_wr_req, opd_wr_ack;
    logic [DW-1:0] opd_rdata, opd_wdata;
    logic [SW-1:0] beat_size;
    logic [LW-1:0] beat_off;
    logic          areg_upd, areg_dec;
    logic [2:0]    areg_sel;
    logic [LW-1:0] areg_amt;
    logic          ctl_abort, trap, done;

    always #2 clk = ~clk;

    cpxfer_seq #(.LW(LW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .prim_valid(prim_valid), .prim_dir(prim_dir),
        .prim_class(prim_class), .prim_len(prim_len), .ea_mode(ea_mode), .ea_reg(ea_reg),
        .prim_take(prim_take), .mem_req(mem_req), .mem_we(mem_we), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .reg_req(reg_req), .reg_we(reg_we),
        .reg_sel(reg_sel), .reg_rdata(reg_rdata), .reg_wdata(reg_wdata), .reg_ack(reg_ack),
        .opd_rd_req(opd_rd_req), .opd_rdata(opd_rdata), .opd_rd_ack(opd_rd_ack),
        .opd_wr_req(opd_wr_req), .opd_wdata(opd_wdata), .opd_wr_ack(opd_wr_ack),
        .beat_size(beat_size), .beat_off(beat_off), .areg_upd(areg_upd), .areg_dec(areg_dec),
        .areg_sel(areg_sel), .areg_amt(areg_amt), .ctl_abort(ctl_abort), .trap(trap),
        .done(done)
    );

    int n_checks = 0;
    int n_err = 0;
    int cyc = 0;

    function automatic void chk(input bit ok, input string req, input logic [31:0] act,
                                input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endfunction

    function automatic logic [31:0] mem_pat(input logic [7:0] o);  return {8'hA5, 16'h0, o}; endfunction
    function automatic logic [31:0] reg_pat(input logic [7:0] o);  return {8'h5E, 16'h0, o}; endfunction
    function automatic logic [31:0] opd_pat(input logic [7:0] o);  return {8'h0D, 16'h0, o}; endfunction

    function automatic bit e_class_ok(input int c, input int m);
        bit is_reg = (m < 2);
        bit is_an  = (m == 1);
        bit is_imm = (m == 7);
        bit incdec = (m == 3) || (m == 4);
        case (c)
            0: return !is_reg && !is_imm && !incdec;
            1: return !is_imm;
            2: return !is_imm && !is_reg;
            3: return !is_imm && !is_an;
            4: return !is_an;
            5: return !is_reg;
            6: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit e_len_ok(input int m, input int l, input bit d);
        if (l == 0) return 1'b0;
        if (m < 2) return (l == 1) || (l == 2) || (l == 4);
        if (m == 7) return ((l == 1) || (l % 2 == 0)) && !d;
        return 1'b1;
    endfunction

    // simple handshake responders: acknowledge one cycle after a request
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0; reg_ack <= 1'b0; opd_rd_ack <= 1'b0; opd_wr_ack <= 1'b0;
            mem_rdata <= '0; reg_rdata <= '0; opd_rdata <= '0;
        end else begin
            mem_ack    <= mem_req && !mem_ack;
            reg_ack    <= reg_req && !reg_ack;
            opd_rd_ack <= opd_rd_req && !opd_rd_ack;
            opd_wr_ack <= opd_wr_req && !opd_wr_ack;
            if (mem_req && !mem_ack && !mem_we) mem_rdata <= mem_pat(beat_off);
            if (reg_req && !reg_ack && !reg_we) reg_rdata <= reg_pat(beat_off);
            if (opd_rd_req && !opd_rd_ack)      opd_rdata <= opd_pat(beat_off);
        end
    end

    always @(posedge clk) cyc <= cyc + 1;

    // current transaction as the bench intends it
    bit       cur_dir;
    bit [2:0] cur_mode, cur_reg;
    int       cur_len;

    int m_take, m_fetch, m_store, m_bytes, m_upd, m_abort, m_trap, m_done;
    int m_upd_fetch, m_upd_store, m_upd_amt, m_abort_cyc, m_trap_cyc, m_done_cyc, m_last_store;
    bit m_upd_dec;
    int m_upd_sel;

    always @(negedge clk) begin
        if (rst_n) begin
            bit regdir;
            bit f_ack, s_ack;
            int left;
            regdir = (cur_mode < 3'd2);
            f_ack = (mem_req && mem_ack && !mem_we) || (reg_req && reg_ack && !reg_we) ||
                    (opd_rd_req && opd_rd_ack);
            s_ack = (mem_req && mem_ack && mem_we) || (reg_req && reg_ack && reg_we) ||
                    (opd_wr_req && opd_wr_ack);
            if (prim_take) m_take++;
            if (f_ack) begin
                m_fetch++;
                m_bytes += int'(beat_size);
                left = cur_len - int'(beat_off);
                chk(int'(beat_size) == ((left > 4) ? 4 : left), "R5", 32'(beat_size),
                    32'((left > 4) ? 4 : left));
                chk(cur_dir ? opd_rd_req : (regdir ? reg_req : mem_req), "R10",
                    {mem_req, reg_req, opd_rd_req}, 32'(cur_dir));
                if (reg_req) chk(reg_sel == {cur_mode[0], cur_reg}, "R3", 32'(reg_sel),
                                 32'({cur_mode[0], cur_reg}));
            end
            if (s_ack) begin
                logic [31:0] e, a;
                m_store++;
                m_last_store = cyc;
                e = cur_dir ? opd_pat(beat_off) : (regdir ? reg_pat(beat_off) : mem_pat(beat_off));
                a = cur_dir ? (regdir ? reg_wdata : mem_wdata) : opd_wdata;
                chk(a == e, "R10", a, e);
                if (reg_req) chk(reg_sel == {cur_mode[0], cur_reg}, "R3", 32'(reg_sel),
                                 32'({cur_mode[0], cur_reg}));
            end
            if (areg_upd) begin
                m_upd++;
                m_upd_dec = areg_dec;
                m_upd_amt = int'(areg_amt);
                m_upd_sel = int'(areg_sel);
                m_upd_fetch = m_fetch;
                m_upd_store = m_store;
            end
            if (ctl_abort) begin m_abort++; m_abort_cyc = cyc; end
            if (trap)      begin m_trap++;  m_trap_cyc = cyc;  end
            if (done)      begin m_done++;  m_done_cyc = cyc;  end
        end
    end

    task automatic run(input bit d, input int c, input int l, input int m, input int r);
        bit fin = 1'b0;
        bit cok, lok;
        int nb, amt;
        string why;
        @(posedge clk); #1;
        m_take = 0; m_fetch = 0; m_store = 0; m_bytes = 0; m_upd = 0;
        m_abort = 0; m_trap = 0; m_done = 0; m_last_store = 0;
        cur_dir = d; cur_mode = 3'(m); cur_reg = 3'(r); cur_len = l;
        prim_dir = d; prim_class = 3'(c); prim_len = LW'(l); ea_mode = 3'(m); ea_reg = 3'(r);
        prim_valid = 1'b1;
        @(negedge clk);
        chk(prim_take, "R1", 32'(prim_take), 32'd1);
        @(posedge clk); #1;
        // the request turns into something else right after it was read
        prim_dir = ~d; prim_class = 3'($urandom_range(0, 7)); prim_len = LW'($urandom_range(0, 255));
        ea_mode = 3'($urandom_range(0, 7)); ea_reg = 3'($urandom_range(0, 7));
        for (int i = 0; i < 400 && !fin; i++) begin
            @(negedge clk);
            if (done || trap) fin = 1'b1;
        end
        prim_valid = 1'b0;
        chk(fin, "R11", 32'(fin), 32'd1);
        @(negedge clk);
        chk(m_take == 1, "R1", 32'(m_take), 32'd1);
        cok = e_class_ok(c, m);
        lok = e_len_ok(m, l, d);
        if (!cok)      why = "R2";
        else if (m < 2) why = "R3";
        else if (m == 7) why = "R4";
        else            why = "R5";
        if (!(cok && lok)) begin
            chk(m_abort == 1, why, 32'(m_abort), 32'd1);
            chk(m_trap == 1 && m_trap_cyc == m_abort_cyc + 1, "R9", 32'(m_trap_cyc),
                32'(m_abort_cyc + 1));
            chk(m_fetch + m_store + m_upd == 0, "R9", 32'(m_fetch + m_store + m_upd), 32'd0);
            chk(m_done == 0, "R9", 32'(m_done), 32'd0);
        end else begin
            nb = (m < 2) ? 1 : (l + 3) / 4;
            amt = (r == 7 && l == 1) ? 2 : l;
            chk(m_abort == 0 && m_trap == 0, why, 32'(m_abort + m_trap), 32'd0);
            chk(m_fetch == nb && m_store == nb, "R5", 32'(m_store), 32'(nb));
            chk(m_bytes == l, "R5", 32'(m_bytes), 32'(l));
            chk(m_done == 1, "R11", 32'(m_done), 32'd1);
            if (m == 4) begin
                chk(m_upd == 1 && m_upd_dec && m_upd_fetch == 0 && m_upd_sel == r, "R6",
                    32'(m_upd_fetch), 32'd0);
                chk(m_upd_amt == amt, (amt != l) ? "R8" : "R6", 32'(m_upd_amt), 32'(amt));
                chk(m_done_cyc == m_last_store + 1, "R11", 32'(m_done_cyc), 32'(m_last_store + 1));
            end else if (m == 3) begin
                chk(m_upd == 1 && !m_upd_dec && m_upd_store == nb && m_upd_sel == r, "R7",
                    32'(m_upd_store), 32'(nb));
                chk(m_upd_amt == amt, (amt != l) ? "R8" : "R7", 32'(m_upd_amt), 32'(amt));
                chk(m_done_cyc == m_last_store + 2, "R11", 32'(m_done_cyc), 32'(m_last_store + 2));
            end else begin
                chk(m_upd == 0, "R7", 32'(m_upd), 32'd0);
                chk(m_done_cyc == m_last_store + 1, "R11", 32'(m_done_cyc), 32'(m_last_store + 1));
            end
        end
    endtask

    initial begin
        wait (cyc >= 150000);
        n_err++;
        $display("FAIL R11: watchdog expired actual %0d expected below %0d", cyc, 150000);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681357));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({prim_take, mem_req, reg_req, opd_rd_req, opd_wr_req, areg_upd, ctl_abort, trap,
             done} == '0, "R1",
            32'({prim_take, mem_req, reg_req, opd_rd_req, opd_wr_req, areg_upd, ctl_abort,
                 trap, done}), 32'd0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        run(1'b0, 6, 1, 4, 7);   // R8 predecrement stack pointer, byte
        run(1'b0, 6, 1, 3, 7);   // R8 postincrement stack pointer, byte
        run(1'b1, 6, 1, 3, 3);   // R7 ordinary register steps by one
        run(1'b1, 2, 7, 5, 0);   // R5 beats of 4 then 3
        run(1'b0, 4, 3, 0, 2);   // R3 odd length on data register
        run(1'b1, 3, 4, 0, 5);   // R3 register write
        run(1'b0, 4, 3, 7, 0);   // R4 odd immediate above one
        run(1'b0, 4, 6, 7, 0);   // R4 even immediate
        run(1'b1, 6, 2, 7, 0);   // R4 immediate toward location
        run(1'b0, 0, 4, 3, 1);   // R2 postincrement is not control
        run(1'b0, 7, 4, 6, 0);   // R2 reserved class
        run(1'b0, 5, 0, 6, 0);   // R5 zero length
        run(1'b1, 1, 2, 1, 4);   // R3 address register direct
        run(1'b0, 6, 12, 4, 2);  // R6 multi-beat predecrement

        for (int k = 0; k < 250; k++) begin
            int ln;
            if ($urandom_range(0, 9) < 7) ln = $urandom_range(0, 8);
            else ln = $urandom_range(9, 40);
            run(1'($urandom_range(0, 1)), $urandom_range(0, 7), ln, $urandom_range(0, 7),
                $urandom_range(0, 7));
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule